// File: doc/BRIEF.md
# Multi-Cycle Instruction Sequencer

This block is the control state machine of a 32-bit processor whose datapath is built around two source buses (A and B) and one result bus (C). It holds a 6-bit step counter and, from the current step, the 5-bit opcode held in the instruction register, the 4-bit floating-point sub-operation and a condition flag from the datapath, it drives every register load enable, the source selects for the three buses, the memory read and write strobes, and the function codes for the integer and floating-point units.

Every instruction starts with the same two fetch steps. Execution then takes a number of steps that depends on the instruction class: one step for most operations, two for a store, three for a load, and long runs for the iterative divide and the floating-point reciprocal. After the final step of an instruction the counter goes back to step 1. A halt instruction freezes the sequencer until reset.

Top module: `instr_sequencer`

## Requirements
- R1: After a synchronous active-low reset the step output is 1 and halted is 0. In step 1 reg_en is 8'h03 (PC and MD), mem_rd is 1, a_sel is 4'b0010 (PC), b_sel is 3'b100 (constant one), c_sel is 5'b00001 (integer unit) and alu_fn is 2 (add).
- R2: In step 2 reg_en is 8'h04 (IR only), a_sel is 4'b1000 (MD), alu_fn is 1 (pass A) and no memory strobe is active.
- R3: The step output counts 1, 2, 3, ... and returns to 1 after the last step. Instructions take 3 cycles except: store (opcode 2) takes 4, load (opcode 0) takes 5, divide (opcode 15) takes 2+DIV_STEPS (34 by default), and opcode 27 with sub-operation 7 (reciprocal) takes 2+RCP_STEPS (9 by default). In the single execution step, register and ALU operations (opcodes 1, 3-13, 16, 17), moves and input (21, 23, 24) set reg_en bit 4 (rA write), multiply (14) sets bit 6 (HI/LO), output (22) sets bit 7, jump (19) sets bit 0 (PC), and opcode 27 with any other sub-operation sets bit 4 with fpu_go 1 and fpu_fn equal to the sub-operation.
- R4: A store sets reg_en bit 3 (MA) in step 3 with a_sel RB and b_sel constant, and in step 4 asserts only mem_wr with a_sel 4'b0100 (rA) and reg_en 0.
- R5: A load sets reg_en bit 3 (MA) in step 3, asserts mem_rd with reg_en bit 1 (MD) in step 4, and sets reg_en bit 4 (rA write) in step 5.
- R6: A conditional branch (opcode 18) sets reg_en bit 0 (PC) in step 3 when cond_true is 1, and sets no enable when it is 0.
- R7: Jump-and-link (opcode 20) sets reg_en bits 0 and 5 (PC and link register) together in step 3, with a_sel 4'b0100 (rA).
- R8: During every execution step of divide alu_fn is 11 and during every execution step of reciprocal fpu_go is 1; the result enable (bit 6 for divide, bit 4 for reciprocal) is set only in the last step.
- R9: After step 3 of a halt (opcode 26) halted is 1, the step output stays at 3 and every enable, select and strobe output is 0 until reset.
- R10: a_sel, b_sel and c_sel are each one-hot or all-zero in every cycle, and mem_rd and mem_wr are never both 1.
- R11: Reset taken in the middle of any instruction, or while halted, returns the step output to 1 and halted to 0 at the next clock edge.
- R12: No-operation (opcode 25) and the unused opcodes 28-31 run for 3 cycles and set no enable and no memory strobe in step 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode | input | 5 | Opcode field from the instruction register |
| fpu_op | input | 4 | Floating-point sub-operation field |
| cond_true | input | 1 | Branch condition result from the datapath |
| step | output | 6 | Current step number, 1 is the first fetch step |
| halted | output | 1 | Sequencer stopped by a halt instruction |
| reg_en | output | 8 | Load enables: 0 PC, 1 MD, 2 IR, 3 MA, 4 rA write, 5 link register, 6 HI/LO, 7 output port |
| a_sel | output | 4 | Bus A source, one-hot: 0 rB, 1 PC, 2 rA, 3 MD |
| b_sel | output | 3 | Bus B source, one-hot: 0 rC, 1 sign-extended constant, 2 constant one |
| c_sel | output | 5 | Bus C source, one-hot: 0 integer unit, 1 float unit, 2 HI, 3 LO, 4 input port |
| alu_fn | output | 4 | Integer unit function: 0 none, 1 pass, 2 add, 3 sub, 4 shr, 5 shl, 6 ror, 7 rol, 8 and, 9 or, 10 mul, 11 div, 12 neg, 13 not |
| fpu_go | output | 1 | Float unit active this step |
| fpu_fn | output | 4 | Float unit function, the sub-operation when fpu_go is 1 |
| mem_rd | output | 1 | Memory read into MD |
| mem_wr | output | 1 | Memory write of bus A |

## Verification
The bench sweeps all 32 opcodes, and for opcode 27 all 16 sub-operations, each with the branch condition both low and high, and walks every step of each instruction against a length and an enable pattern derived from the instruction class. The sweep separates the classes by their cycle count (3, 4, 5, 9 and 34), and the paired condition values show that only the branch reacts to cond_true. Halt is followed for several cycles to show the frozen state, and a reset in the middle of a divide and during halt shows the restart of fetch.

// File: rtl/seq_pkg.sv
// Package seq_pkg
// Shared encodings for the instruction sequencer: opcode values, enable bit
// positions, bus source positions, integer function codes and the control
// bundle type. Opcode values are fixed because the instruction register
// field is decoded against them.
package seq_pkg;

    localparam int OP_W  = 5;
    localparam int FOP_W = 4;

    // Opcode values
    localparam logic [OP_W-1:0] OPC_LOAD   = 5'd0;
    localparam logic [OP_W-1:0] OPC_LDIMM  = 5'd1;
    localparam logic [OP_W-1:0] OPC_STORE  = 5'd2;
    localparam logic [OP_W-1:0] OPC_ADD    = 5'd3;
    localparam logic [OP_W-1:0] OPC_SUB    = 5'd4;
    localparam logic [OP_W-1:0] OPC_SHR    = 5'd5;
    localparam logic [OP_W-1:0] OPC_SHL    = 5'd6;
    localparam logic [OP_W-1:0] OPC_ROR    = 5'd7;
    localparam logic [OP_W-1:0] OPC_ROL    = 5'd8;
    localparam logic [OP_W-1:0] OPC_AND    = 5'd9;
    localparam logic [OP_W-1:0] OPC_OR     = 5'd10;
    localparam logic [OP_W-1:0] OPC_ADDI   = 5'd11;
    localparam logic [OP_W-1:0] OPC_ANDI   = 5'd12;
    localparam logic [OP_W-1:0] OPC_ORI    = 5'd13;
    localparam logic [OP_W-1:0] OPC_MUL    = 5'd14;
    localparam logic [OP_W-1:0] OPC_DIV    = 5'd15;
    localparam logic [OP_W-1:0] OPC_NEG    = 5'd16;
    localparam logic [OP_W-1:0] OPC_NOT    = 5'd17;
    localparam logic [OP_W-1:0] OPC_BRANCH = 5'd18;
    localparam logic [OP_W-1:0] OPC_JUMP   = 5'd19;
    localparam logic [OP_W-1:0] OPC_CALL   = 5'd20;
    localparam logic [OP_W-1:0] OPC_IN     = 5'd21;
    localparam logic [OP_W-1:0] OPC_OUT    = 5'd22;
    localparam logic [OP_W-1:0] OPC_GETHI  = 5'd23;
    localparam logic [OP_W-1:0] OPC_GETLO  = 5'd24;
    localparam logic [OP_W-1:0] OPC_IDLE   = 5'd25;
    localparam logic [OP_W-1:0] OPC_STOP   = 5'd26;
    localparam logic [OP_W-1:0] OPC_FLOAT  = 5'd27;

    // Float sub-operation that runs for several steps
    localparam logic [FOP_W-1:0] FOP_RECIP = 4'd7;

    // Register load enable bit positions
    localparam int EN_W    = 8;
    localparam int EN_PC   = 0;
    localparam int EN_MD   = 1;
    localparam int EN_IR   = 2;
    localparam int EN_MA   = 3;
    localparam int EN_RA   = 4;
    localparam int EN_LINK = 5;
    localparam int EN_HILO = 6;
    localparam int EN_OUT  = 7;

    // Bus A sources
    localparam int A_W  = 4;
    localparam int A_RB = 0;
    localparam int A_PC = 1;
    localparam int A_RA = 2;
    localparam int A_MD = 3;

    // Bus B sources
    localparam int B_W     = 3;
    localparam int B_RC    = 0;
    localparam int B_CONST = 1;
    localparam int B_ONE   = 2;

    // Bus C sources
    localparam int C_W   = 5;
    localparam int C_INT = 0;
    localparam int C_FLT = 1;
    localparam int C_HI  = 2;
    localparam int C_LO  = 3;
    localparam int C_IN  = 4;

    typedef enum logic [3:0] {
        FN_NONE = 4'd0,
        FN_PASS = 4'd1,
        FN_ADD  = 4'd2,
        FN_SUB  = 4'd3,
        FN_SHR  = 4'd4,
        FN_SHL  = 4'd5,
        FN_ROR  = 4'd6,
        FN_ROL  = 4'd7,
        FN_AND  = 4'd8,
        FN_OR   = 4'd9,
        FN_MUL  = 4'd10,
        FN_DIV  = 4'd11,
        FN_NEG  = 4'd12,
        FN_NOT  = 4'd13
    } alu_fn_e;

    typedef struct packed {
        logic [EN_W-1:0]  en;
        logic [A_W-1:0]   a;
        logic [B_W-1:0]   b;
        logic [C_W-1:0]   c;
        alu_fn_e          fn;
        logic             fgo;
        logic [FOP_W-1:0] ffn;
        logic             rd;
        logic             wr;
    } ctrl_t;

endpackage

// File: rtl/seq_length_decode.sv
// Module seq_length_decode
// Gives the number of the final step of the instruction in the instruction
// register, counting the two fetch steps. Assumes the opcode and sub-operation
// inputs are stable from step 3 onwards; during fetch the result is unused.
module seq_length_decode
    import seq_pkg::*;
#(
    parameter int STEP_W    = 6,
    parameter int DIV_STEPS = 32,
    parameter int RCP_STEPS = 7
) (
    input  logic [OP_W-1:0]   opcode,
    input  logic [FOP_W-1:0]  fpu_op,
    output logic [STEP_W-1:0] last_step,
    output logic              is_stop
);
    localparam int FETCH_STEPS = 2;
    localparam logic [STEP_W-1:0] LAST_ONE  = STEP_W'(FETCH_STEPS + 1);
    localparam logic [STEP_W-1:0] LAST_ST   = STEP_W'(FETCH_STEPS + 2);
    localparam logic [STEP_W-1:0] LAST_LD   = STEP_W'(FETCH_STEPS + 3);
    localparam logic [STEP_W-1:0] LAST_DIV  = STEP_W'(FETCH_STEPS + DIV_STEPS);
    localparam logic [STEP_W-1:0] LAST_RCP  = STEP_W'(FETCH_STEPS + RCP_STEPS);

    // Select the final step number by instruction class
    always_comb begin
        is_stop = (opcode == OPC_STOP);
        unique case (opcode)
            OPC_LOAD:  last_step = LAST_LD;
            OPC_STORE: last_step = LAST_ST;
            OPC_DIV:   last_step = LAST_DIV;
            OPC_FLOAT: last_step = (fpu_op == FOP_RECIP) ? LAST_RCP : LAST_ONE;
            default:   last_step = LAST_ONE;
        endcase
    end
endmodule

// File: rtl/seq_step_counter.sv
// Module seq_step_counter
// Holds the step number and the halted flag. Advances by one each cycle,
// wraps to step 1 after the final step, and freezes on a halt instruction.
// Assumes at_last is only true from step 3 on.
module seq_step_counter #(
    parameter int STEP_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              at_last,
    input  logic              is_stop,
    output logic [STEP_W-1:0] step_q,
    output logic              halted_q
);
    localparam logic [STEP_W-1:0] FIRST = STEP_W'(1);

    // Step and halt state, synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q   <= FIRST;
            halted_q <= 1'b0;
        end else if (!halted_q) begin
            if (at_last && is_stop) begin
                halted_q <= 1'b1;
            end else if (at_last) begin
                step_q <= FIRST;
            end else begin
                step_q <= step_q + FIRST;
            end
        end
    end
endmodule

// File: rtl/seq_ctrl_decode.sv
// Module seq_ctrl_decode
// Purely combinational decode of the control bundle from the current step,
// the instruction fields and the branch condition. Fetch steps ignore the
// instruction fields. A halted sequencer drives an all-zero bundle.
module seq_ctrl_decode
    import seq_pkg::*;
#(
    parameter int STEP_W = 6
) (
    input  logic [STEP_W-1:0] step,
    input  logic              at_last,
    input  logic              halted,
    input  logic [OP_W-1:0]   opcode,
    input  logic [FOP_W-1:0]  fpu_op,
    input  logic              cond_true,
    output ctrl_t             ctl
);
    localparam logic [STEP_W-1:0] S1 = STEP_W'(1);
    localparam logic [STEP_W-1:0] S2 = STEP_W'(2);
    localparam logic [STEP_W-1:0] S3 = STEP_W'(3);
    localparam logic [STEP_W-1:0] S4 = STEP_W'(4);
    localparam logic [STEP_W-1:0] S5 = STEP_W'(5);

    // Integer function for the register-register operations
    function automatic alu_fn_e rr_fn(input logic [OP_W-1:0] op);
        unique case (op)
            OPC_ADD: rr_fn = FN_ADD;
            OPC_SUB: rr_fn = FN_SUB;
            OPC_SHR: rr_fn = FN_SHR;
            OPC_SHL: rr_fn = FN_SHL;
            OPC_ROR: rr_fn = FN_ROR;
            OPC_ROL: rr_fn = FN_ROL;
            OPC_AND: rr_fn = FN_AND;
            OPC_OR:  rr_fn = FN_OR;
            default: rr_fn = FN_NONE;
        endcase
    endfunction

    // Control bundle for the current step
    always_comb begin
        ctl = '0;
        if (halted) begin
            ctl = '0;
        end else if (step == S1) begin
            ctl.en[EN_PC] = 1'b1;
            ctl.en[EN_MD] = 1'b1;
            ctl.rd        = 1'b1;
            ctl.a[A_PC]   = 1'b1;
            ctl.b[B_ONE]  = 1'b1;
            ctl.c[C_INT]  = 1'b1;
            ctl.fn        = FN_ADD;
        end else if (step == S2) begin
            ctl.en[EN_IR] = 1'b1;
            ctl.a[A_MD]   = 1'b1;
            ctl.c[C_INT]  = 1'b1;
            ctl.fn        = FN_PASS;
        end else begin
            unique case (opcode)
                OPC_LOAD, OPC_STORE: begin
                    if (step == S3) begin
                        ctl.en[EN_MA]  = 1'b1;
                        ctl.a[A_RB]    = 1'b1;
                        ctl.b[B_CONST] = 1'b1;
                        ctl.c[C_INT]   = 1'b1;
                        ctl.fn         = FN_ADD;
                    end else if (step == S4 && opcode == OPC_LOAD) begin
                        ctl.en[EN_MD] = 1'b1;
                        ctl.rd        = 1'b1;
                    end else if (step == S4) begin
                        ctl.wr      = 1'b1;
                        ctl.a[A_RA] = 1'b1;
                    end else if (step == S5) begin
                        ctl.en[EN_RA] = 1'b1;
                        ctl.a[A_MD]   = 1'b1;
                        ctl.c[C_INT]  = 1'b1;
                        ctl.fn        = FN_PASS;
                    end
                end
                OPC_LDIMM, OPC_ADDI, OPC_ANDI, OPC_ORI: begin
                    ctl.en[EN_RA]  = 1'b1;
                    ctl.a[A_RB]    = 1'b1;
                    ctl.b[B_CONST] = 1'b1;
                    ctl.c[C_INT]   = 1'b1;
                    ctl.fn = (opcode == OPC_ANDI) ? FN_AND :
                             (opcode == OPC_ORI)  ? FN_OR  : FN_ADD;
                end
                OPC_ADD, OPC_SUB, OPC_SHR, OPC_SHL,
                OPC_ROR, OPC_ROL, OPC_AND, OPC_OR: begin
                    ctl.en[EN_RA] = 1'b1;
                    ctl.a[A_RB]   = 1'b1;
                    ctl.b[B_RC]   = 1'b1;
                    ctl.c[C_INT]  = 1'b1;
                    ctl.fn        = rr_fn(opcode);
                end
                OPC_MUL, OPC_DIV: begin
                    ctl.a[A_RB]     = 1'b1;
                    ctl.b[B_RC]     = 1'b1;
                    ctl.fn          = (opcode == OPC_MUL) ? FN_MUL : FN_DIV;
                    ctl.en[EN_HILO] = (opcode == OPC_MUL) || at_last;
                end
                OPC_NEG, OPC_NOT: begin
                    ctl.en[EN_RA] = 1'b1;
                    ctl.a[A_RB]   = 1'b1;
                    ctl.c[C_INT]  = 1'b1;
                    ctl.fn        = (opcode == OPC_NEG) ? FN_NEG : FN_NOT;
                end
                OPC_BRANCH: begin
                    ctl.en[EN_PC]  = cond_true;
                    ctl.a[A_PC]    = 1'b1;
                    ctl.b[B_CONST] = 1'b1;
                    ctl.c[C_INT]   = 1'b1;
                    ctl.fn         = FN_ADD;
                end
                OPC_JUMP, OPC_CALL: begin
                    ctl.en[EN_PC]   = 1'b1;
                    ctl.en[EN_LINK] = (opcode == OPC_CALL);
                    ctl.a[A_RA]     = 1'b1;
                    ctl.c[C_INT]    = 1'b1;
                    ctl.fn          = FN_PASS;
                end
                OPC_IN: begin
                    ctl.en[EN_RA] = 1'b1;
                    ctl.c[C_IN]   = 1'b1;
                end
                OPC_OUT: begin
                    ctl.en[EN_OUT] = 1'b1;
                    ctl.a[A_RA]    = 1'b1;
                end
                OPC_GETHI, OPC_GETLO: begin
                    ctl.en[EN_RA] = 1'b1;
                    ctl.c[C_HI]   = (opcode == OPC_GETHI);
                    ctl.c[C_LO]   = (opcode == OPC_GETLO);
                end
                OPC_FLOAT: begin
                    ctl.fgo       = 1'b1;
                    ctl.ffn       = fpu_op;
                    ctl.a[A_RB]   = 1'b1;
                    ctl.b[B_RC]   = 1'b1;
                    ctl.c[C_FLT]  = 1'b1;
                    ctl.en[EN_RA] = (fpu_op != FOP_RECIP) || at_last;
                end
                default: ctl = '0;
            endcase
        end
    end
endmodule

// File: rtl/instr_sequencer.sv
// Module instr_sequencer
// Top of the multi-cycle instruction sequencer. Combines the final-step
// decode, the step counter and the control decode; outputs are a function
// of the registered step and the current instruction fields.
// Assumes opcode and fpu_op hold the instruction register contents.
module instr_sequencer
    import seq_pkg::*;
#(
    parameter int STEP_W    = 6,
    parameter int DIV_STEPS = 32,
    parameter int RCP_STEPS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        opcode,
    input  logic [3:0]        fpu_op,
    input  logic              cond_true,
    output logic [STEP_W-1:0] step,
    output logic              halted,
    output logic [7:0]        reg_en,
    output logic [3:0]        a_sel,
    output logic [2:0]        b_sel,
    output logic [4:0]        c_sel,
    output logic [3:0]        alu_fn,
    output logic              fpu_go,
    output logic [3:0]        fpu_fn,
    output logic              mem_rd,
    output logic              mem_wr
);
    logic [STEP_W-1:0] last_step;
    logic              is_stop;
    logic              at_last;
    ctrl_t             ctl;

    seq_length_decode #(
        .STEP_W(STEP_W), .DIV_STEPS(DIV_STEPS), .RCP_STEPS(RCP_STEPS)
    ) u_len (
        .opcode(opcode), .fpu_op(fpu_op),
        .last_step(last_step), .is_stop(is_stop)
    );

    // Final-step flag shared by the counter and the decode
    assign at_last = (step == last_step);

    seq_step_counter #(.STEP_W(STEP_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .at_last(at_last), .is_stop(is_stop),
        .step_q(step), .halted_q(halted)
    );

    seq_ctrl_decode #(.STEP_W(STEP_W)) u_dec (
        .step(step), .at_last(at_last), .halted(halted),
        .opcode(opcode), .fpu_op(fpu_op), .cond_true(cond_true),
        .ctl(ctl)
    );

    // Unpack the control bundle onto the ports
    assign reg_en = ctl.en;
    assign a_sel  = ctl.a;
    assign b_sel  = ctl.b;
    assign c_sel  = ctl.c;
    assign alu_fn = ctl.fn;
    assign fpu_go = ctl.fgo;
    assign fpu_fn = ctl.ffn;
    assign mem_rd = ctl.rd;
    assign mem_wr = ctl.wr;
endmodule

// File: rtl/seq_checker.sv
// Module seq_checker
// Temporal checks on the sequencer ports, bound to every instr_sequencer.
module seq_checker #(
    parameter int STEP_W   = 6,
    parameter int MAX_STEP = 34
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        opcode,
    input logic              cond_true,
    input logic [STEP_W-1:0] step,
    input logic              halted,
    input logic [7:0]        reg_en,
    input logic [3:0]        a_sel,
    input logic [2:0]        b_sel,
    input logic [4:0]        c_sel,
    input logic              mem_rd,
    input logic              mem_wr
);
    // R11
    reset_to_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (step == STEP_W'(1) && !halted));

    // R10
    a_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(a_sel));

    // R10
    b_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(b_sel));

    // R10
    c_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(c_sel));

    // R10
    mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R9
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(step)));

    // R9
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (reg_en == 8'h00 && !mem_rd && !mem_wr && a_sel == 4'h0));

    // R3
    step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(step) >= 1 && int'(step) <= MAX_STEP));

    // R6
    branch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step == STEP_W'(3) && opcode == 5'd18 && !cond_true) |-> !reg_en[0]);
endmodule

bind instr_sequencer seq_checker #(
    .STEP_W(STEP_W),
    .MAX_STEP(2 + ((DIV_STEPS > RCP_STEPS) ? DIV_STEPS : RCP_STEPS))
) u_seq_chk (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .cond_true(cond_true),
    .step(step), .halted(halted), .reg_en(reg_en),
    .a_sel(a_sel), .b_sel(b_sel), .c_sel(c_sel),
    .mem_rd(mem_rd), .mem_wr(mem_wr)
);

// File: tb/instr_sequencer_test.sv
`timescale 1ns/1ps
module instr_sequencer_test;
    localparam int DIV_N = 32;
    localparam int RCP_N = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] opcode = 5'd0;
    logic [3:0] fpu_op = 4'd0;
    logic       cond_true = 1'b0;
    logic [5:0] step;
    logic       halted;
    logic [7:0] reg_en;
    logic [3:0] a_sel;
    logic [2:0] b_sel;
    logic [4:0] c_sel;
    logic [3:0] alu_fn;
    logic       fpu_go;
    logic [3:0] fpu_fn;
    logic       mem_rd;
    logic       mem_wr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    instr_sequencer #(.STEP_W(6), .DIV_STEPS(DIV_N), .RCP_STEPS(RCP_N)) uut (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .fpu_op(fpu_op),
        .cond_true(cond_true), .step(step), .halted(halted), .reg_en(reg_en),
        .a_sel(a_sel), .b_sel(b_sel), .c_sel(c_sel), .alu_fn(alu_fn),
        .fpu_go(fpu_go), .fpu_fn(fpu_fn), .mem_rd(mem_rd), .mem_wr(mem_wr)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s op=%0d fop=%0d cond=%0d actual=%0d expected=%0d",
                     req, what, opcode, fpu_op, cond_true, act, exp);
        end
    endtask

    function automatic int exp_len(input int op, input int fop);
        if (op == 0) return 5;
        if (op == 2) return 4;
        if (op == 15) return 2 + DIV_N;
        if (op == 27 && fop == 7) return 2 + RCP_N;
        return 3;
    endfunction

    // Expected enables in execution step k of an instruction of length len
    function automatic int exp_en(input int op, input int fop, input bit c, input int k, input int len);
        case (op)
            0:  return (k == 3) ? 8 : (k == 4) ? 2 : 16;
            2:  return (k == 3) ? 8 : 0;
            1, 3, 4, 5, 6, 7, 8, 9, 10, 11, 12, 13, 16, 17, 21, 23, 24: return 16;
            14: return 64;
            15: return (k == len) ? 64 : 0;
            18: return c ? 1 : 0;
            19: return 1;
            20: return 33;
            22: return 128;
            27: return (fop != 7 || k == len) ? 16 : 0;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(input int op, input int fop);
        case (op)
            0:  return "R5";
            2:  return "R4";
            15: return "R8";
            18: return "R6";
            20: return "R7";
            25, 28, 29, 30, 31: return "R12";
            27: return (fop == 7) ? "R8" : "R3";
            default: return "R3";
        endcase
    endfunction

    // Called at a falling edge; leaves the design in step 1 at a falling edge
    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1", "reset step", int'(step), 1);
        chk("R1", "reset halted", int'(halted), 0);
    endtask

    task automatic run_one(input int op, input int fop, input bit c);
        int len;
        string t;
        opcode = 5'(op);
        fpu_op = 4'(fop);
        cond_true = c;
        do_reset();
        len = exp_len(op, fop);
        t = tag_of(op, fop);
        for (int k = 1; k <= len; k++) begin
            chk("R3", "step", int'(step), k);
            chk("R10", "a onehot0", ($countones(a_sel) <= 1) ? 1 : 0, 1);
            chk("R10", "b onehot0", ($countones(b_sel) <= 1) ? 1 : 0, 1);
            chk("R10", "c onehot0", ($countones(c_sel) <= 1) ? 1 : 0, 1);
            if (k == 1) begin
                chk("R1", "fetch1 en", int'(reg_en), 3);
                chk("R1", "fetch1 rd", int'(mem_rd), 1);
                chk("R1", "fetch1 a", int'(a_sel), 2);
                chk("R1", "fetch1 b", int'(b_sel), 4);
                chk("R1", "fetch1 c", int'(c_sel), 1);
                chk("R1", "fetch1 fn", int'(alu_fn), 2);
            end else if (k == 2) begin
                chk("R2", "fetch2 en", int'(reg_en), 4);
                chk("R2", "fetch2 a", int'(a_sel), 8);
                chk("R2", "fetch2 fn", int'(alu_fn), 1);
                chk("R2", "fetch2 mem", int'({mem_rd, mem_wr}), 0);
            end else begin
                chk(t, "exec en", int'(reg_en), exp_en(op, fop, c, k, len));
                chk(t, "exec rd", int'(mem_rd), (op == 0 && k == 4) ? 1 : 0);
                chk(t, "exec wr", int'(mem_wr), (op == 2 && k == 4) ? 1 : 0);
                if (op == 2 && k == 4) chk("R4", "store a", int'(a_sel), 4);
                if (op == 20) chk("R7", "call a", int'(a_sel), 4);
                if (op == 15) chk("R8", "div fn", int'(alu_fn), 11);
                if (op == 27) begin
                    chk(t, "fpu go", int'(fpu_go), 1);
                    chk(t, "fpu fn", int'(fpu_fn), fop);
                end
            end
            @(negedge clk);
        end
        if (op == 26) begin
            for (int j = 0; j < 4; j++) begin
                chk("R9", "halted", int'(halted), 1);
                chk("R9", "halt step", int'(step), 3);
                chk("R9", "halt outputs", int'({reg_en, a_sel, b_sel, c_sel, mem_rd, mem_wr}), 0);
                @(negedge clk);
            end
        end else begin
            chk("R3", "wrap to 1", int'(step), 1);
        end
    endtask

    initial begin
        @(negedge clk);
        for (int op = 0; op < 32; op++) begin
            if (op == 27) begin
                for (int f = 0; f < 16; f++) begin
                    run_one(op, f, 1'b0);
                    run_one(op, f, 1'b1);
                end
            end else begin
                run_one(op, 0, 1'b0);
                run_one(op, 0, 1'b1);
            end
        end
        // R11: reset part-way through a divide
        opcode = 5'd15;
        fpu_op = 4'd0;
        do_reset();
        repeat (10) @(negedge clk);
        chk("R11", "mid div step", int'(step), 11);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11", "mid reset step", int'(step), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "restart step", int'(step), 2);
        // R11: reset out of halt
        opcode = 5'd26;
        do_reset();
        repeat (5) @(negedge clk);
        chk("R9", "halted before reset", int'(halted), 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11", "halt cleared", int'(halted), 0);
        chk("R11", "halt reset step", int'(step), 1);
        rst_n = 1'b1;
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule